// File: doc/BRIEF.md
# Affinity-Constrained Counter Allocator

This block hands out performance counters to events. A request carries an 8-bit event code. The block looks up the set of counters that may count that event. It then grants the lowest-numbered counter that is both in that set and currently free, and marks it busy in the same step. If no permitted counter is free, it reports a failure and changes nothing.

Counters are returned with a release request that names an index. The block keeps a bitmap of busy counters and drives it as an output, so the surrounding logic can see the occupancy at any time. There are ten counters. Counters 0 and 1 are fixed-function: only the core-cycle event and the all-instructions event can land on them.

Many events are limited to irregular subsets of the counters: a single counter, a group of three, or every other counter. Placement is first-fit and decided one request at a time. The block does not reorder requests to place the most constrained events first.

Top module: `ctr_allocator`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it, `used_map` is all zero and `grant_valid`, `grant_fail` and `rel_err` are 0.
- R2: An event code not named in R3–R7 may use counters 2 through 9 and no others.
- R3: Event code 0x02 may use counter 0 and counters 2 through 9.
- R4: Event code 0x8C may use only counters 1 and 7.
- R5: Event codes 0x01, 0x96, 0x97, 0x9A, 0x9B and 0x9F may use only counter 7.
- R6: Event codes 0x8D, 0x8E, 0x8F, 0x90, 0x93, 0x94, 0x95, 0x98, 0x99, 0x9C, 0xBF, 0xC0, 0xC1, 0xC4, 0xC5, 0xC6, 0xC8, 0xCA and 0xCB may use only counters 5, 6 and 7.
- R7: Event codes 0xF5, 0xF6, 0xF7 and 0xFD may use only counters 2, 4 and 6. Event code 0xF8 may use counters 2 through 7.
- R8: An allocation request sampled at a clock edge grants the lowest-indexed counter that is permitted and free. On the next cycle, `grant_valid` is 1 for one cycle, `grant_idx` holds that index, and bit `grant_idx` of `used_map` is set.
- R9: When no permitted counter is free, `grant_fail` is 1 for one cycle, `grant_valid` is 0, and `used_map` is not changed by the request.
- R10: A release of a busy counter index clears that bit of `used_map` in the following cycle.
- R11: A release and an allocation in the same cycle are both applied, with the release first. The counter just freed can therefore be granted by that allocation.
- R12: A release that names a counter not in use, or an index of 10 or above, leaves `used_map` unchanged. It also raises `rel_err` for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocation request strobe |
| alloc_code | input | 8 | Event code of the allocation request |
| rel_req | input | 1 | Release request strobe |
| rel_idx | input | 4 | Counter index to release |
| grant_valid | output | 1 | Allocation succeeded (one-cycle pulse) |
| grant_idx | output | 4 | Granted counter index |
| grant_fail | output | 1 | Allocation found no permitted free counter |
| rel_err | output | 1 | Release named an idle or invalid counter |
| used_map | output | 10 | Busy bitmap, bit i for counter i |

## Verification
The hardest situations to reach are the ones where a narrow affinity set meets partial occupancy. Examples are a three-counter group whose lowest member is already taken by an unrelated event, and a release that lands in the same cycle as an allocation competing for that very counter.

The bench sweeps all 256 event codes from an empty bitmap. For each code it allocates until failure, then returns every counter, so each code's whole permitted set is walked in grant order. Directed sequences then pre-fill low counters with default-class events before issuing the restricted codes. Finally, a release and an allocation are driven together on a single-counter event.

// File: rtl/ctr_alloc_pkg.sv
package ctr_alloc_pkg;
    localparam int CTR_COUNT = 10;
    localparam int CODE_W    = 8;
    localparam int IDX_W     = $clog2(CTR_COUNT);

    typedef logic [CTR_COUNT-1:0] ctr_mask_t;
    typedef logic [IDX_W-1:0]     ctr_idx_t;
    typedef logic [CODE_W-1:0]    ev_code_t;

    // permitted-counter sets
    localparam ctr_mask_t SET_GENERAL = ctr_mask_t'(10'b11_1111_1100);
    localparam ctr_mask_t SET_CYCLE   = ctr_mask_t'(10'b11_1111_1101);
    localparam ctr_mask_t SET_INSTR   = ctr_mask_t'(10'b00_1000_0010);
    localparam ctr_mask_t SET_SEVEN   = ctr_mask_t'(10'b00_1000_0000);
    localparam ctr_mask_t SET_TRIO    = ctr_mask_t'(10'b00_1110_0000);
    localparam ctr_mask_t SET_EVEN    = ctr_mask_t'(10'b00_0101_0100);
    localparam ctr_mask_t SET_MID     = ctr_mask_t'(10'b00_1111_1100);

    typedef struct packed {
        ctr_mask_t used;
        logic      g_valid;
        logic      g_fail;
        ctr_idx_t  g_idx;
        logic      r_err;
    } alloc_state_t;
endpackage

// File: rtl/ca_affinity.sv
module ca_affinity
    import ctr_alloc_pkg::*;
(
    input  ev_code_t  code,
    output ctr_mask_t allowed
);
    always_comb begin
        case (code) inside
            8'h02: allowed = SET_CYCLE;
            8'h8C: allowed = SET_INSTR;
            8'h01, 8'h96, 8'h97, 8'h9A, 8'h9B, 8'h9F:
                allowed = SET_SEVEN;
            [8'h8D:8'h90], 8'h93, 8'h94, 8'h95, 8'h98, 8'h99, 8'h9C,
            8'hBF, 8'hC0, 8'hC1, 8'hC4, 8'hC5, 8'hC6, 8'hC8, 8'hCA, 8'hCB:
                allowed = SET_TRIO;
            8'hF5, 8'hF6, 8'hF7, 8'hFD:
                allowed = SET_EVEN;
            8'hF8: allowed = SET_MID;
            default: allowed = SET_GENERAL;
        endcase
    end
endmodule

// File: rtl/ca_pick.sv
module ca_pick #(
    parameter int WIDTH = 10,
    parameter int IW    = 4
) (
    input  logic [WIDTH-1:0] cand,
    output logic             found,
    output logic [WIDTH-1:0] onehot,
    output logic [IW-1:0]    idx
);
    // isolate lowest set bit
    assign onehot = cand & (~cand + WIDTH'(1));
    assign found  = |cand;

    logic [WIDTH-1:0][IW-1:0] term;
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_enc
            assign term[g] = onehot[g] ? IW'(g) : '0;
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            idx = idx | term[i];
        end
    end
endmodule

// File: rtl/ca_rel_decode.sv
module ca_rel_decode #(
    parameter int WIDTH = 10,
    parameter int IW    = 4
) (
    input  logic [IW-1:0]    idx,
    output logic [WIDTH-1:0] sel,
    output logic             in_range
);
    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_dec
            assign sel[g] = (idx == IW'(g));
        end
    endgenerate
    assign in_range = |sel;
endmodule

// File: rtl/ctr_allocator.sv
module ctr_allocator
    import ctr_alloc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic [CODE_W-1:0]    alloc_code,
    input  logic                 rel_req,
    input  logic [IDX_W-1:0]     rel_idx,
    output logic                 grant_valid,
    output logic [IDX_W-1:0]     grant_idx,
    output logic                 grant_fail,
    output logic                 rel_err,
    output logic [CTR_COUNT-1:0] used_map
);
    alloc_state_t st_d, st_q;

    ctr_mask_t allowed, rel_sel, cand, pick_oh;
    logic      rel_ok_range, pick_found;
    ctr_idx_t  pick_idx;

    ca_affinity u_aff (
        .code    (alloc_code),
        .allowed (allowed)
    );

    ca_rel_decode #(.WIDTH(CTR_COUNT), .IW(IDX_W)) u_rel (
        .idx      (rel_idx),
        .sel      (rel_sel),
        .in_range (rel_ok_range)
    );

    logic      rel_hit;
    ctr_mask_t used_mid;

    always_comb begin
        rel_hit  = rel_req && rel_ok_range && ((rel_sel & st_q.used) != '0);
        used_mid = rel_hit ? (st_q.used & ~rel_sel) : st_q.used;
        cand     = allowed & ~used_mid;
    end

    ca_pick #(.WIDTH(CTR_COUNT), .IW(IDX_W)) u_pick (
        .cand   (cand),
        .found  (pick_found),
        .onehot (pick_oh),
        .idx    (pick_idx)
    );

    always_comb begin
        st_d         = st_q;
        st_d.g_valid = alloc_req && pick_found;
        st_d.g_fail  = alloc_req && !pick_found;
        st_d.g_idx   = (alloc_req && pick_found) ? pick_idx : '0;
        st_d.used    = (alloc_req && pick_found) ? (used_mid | pick_oh) : used_mid;
        st_d.r_err   = rel_req && !rel_hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant_valid = st_q.g_valid;
    assign grant_idx   = st_q.g_idx;
    assign grant_fail  = st_q.g_fail;
    assign rel_err     = st_q.r_err;
    assign used_map    = st_q.used;
endmodule

// File: rtl/ctr_allocator_chk.sv
module ctr_allocator_chk
    import ctr_alloc_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 alloc_req,
    input logic [CODE_W-1:0]    alloc_code,
    input logic                 rel_req,
    input logic [IDX_W-1:0]     rel_idx,
    input logic                 grant_valid,
    input logic [IDX_W-1:0]     grant_idx,
    input logic                 grant_fail,
    input logic                 rel_err,
    input logic [CTR_COUNT-1:0] used_map
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (used_map == '0 && !grant_valid && !grant_fail && !rel_err));

    // R8
    grant_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant_idx < IDX_W'(CTR_COUNT) && used_map[grant_idx] && !grant_fail));

    // R8
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid || grant_fail) |-> $past(alloc_req));

    // R4
    instr_placement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && $past(alloc_code) == 8'h8C) |-> (grant_idx == 4'd1 || grant_idx == 4'd7));

    // R9
    fail_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_fail && !$past(rel_req)) |-> (used_map == $past(used_map)));

    // R10
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rel_req) && !rel_err && !$past(alloc_req)) |-> !used_map[$past(rel_idx)]);

    // R12
    bad_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_err && !$past(alloc_req)) |-> (used_map == $past(used_map)));
endmodule

bind ctr_allocator ctr_allocator_chk u_chk (.*);

// File: tb/ctr_allocator_test.sv
`timescale 1ns/1ps
module ctr_allocator_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic [7:0] alloc_code = '0;
    logic       rel_req = 1'b0;
    logic [3:0] rel_idx = '0;
    logic       grant_valid, grant_fail, rel_err;
    logic [3:0] grant_idx;
    logic [9:0] used_map;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ctr_allocator uut (.*);

    function automatic logic [9:0] expect_mask(input logic [7:0] c);
        logic [9:0] m = '0;
        if (c == 8'h02) begin m[0] = 1; for (int i = 2; i < 10; i++) m[i] = 1; end
        else if (c == 8'h8C) begin m[1] = 1; m[7] = 1; end
        else if (c == 8'h01 || c == 8'h96 || c == 8'h97 || c == 8'h9A || c == 8'h9B || c == 8'h9F)
            m[7] = 1;
        else if ((c >= 8'h8D && c <= 8'h90) || c == 8'h93 || c == 8'h94 || c == 8'h95 ||
                 c == 8'h98 || c == 8'h99 || c == 8'h9C || c == 8'hBF || c == 8'hC0 ||
                 c == 8'hC1 || c == 8'hC4 || c == 8'hC5 || c == 8'hC6 || c == 8'hC8 ||
                 c == 8'hCA || c == 8'hCB)
            for (int i = 5; i < 8; i++) m[i] = 1;
        else if (c == 8'hF5 || c == 8'hF6 || c == 8'hF7 || c == 8'hFD)
            for (int i = 2; i < 7; i += 2) m[i] = 1;
        else if (c == 8'hF8)
            for (int i = 2; i < 8; i++) m[i] = 1;
        else
            for (int i = 2; i < 10; i++) m[i] = 1;
        return m;
    endfunction

    function automatic string req_of(input logic [7:0] c);
        if (c == 8'h02) return "R3";
        if (c == 8'h8C) return "R4";
        if (c == 8'h01 || c == 8'h96 || c == 8'h97 || c == 8'h9A || c == 8'h9B || c == 8'h9F) return "R5";
        if (expect_mask(c) == 10'b00_1110_0000) return "R6";
        if (c == 8'hF5 || c == 8'hF6 || c == 8'hF7 || c == 8'hFD || c == 8'hF8) return "R7";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v, input string what);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp_v);
        end
    endtask

    task automatic step;
        @(posedge clk);
        #1;
        alloc_req = 0;
        rel_req   = 0;
    endtask

    task automatic do_alloc(input logic [7:0] c);
        alloc_req = 1; alloc_code = c;
        step();
    endtask

    task automatic do_release(input int i);
        rel_req = 1; rel_idx = 4'(i);
        step();
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [9:0] exp_used;
        logic [9:0] m;
        #1;
        step(); step();
        // R1 reset state
        check("R1", 32'(used_map), 0, "used_map in reset");
        check("R1", 32'({grant_valid, grant_fail, rel_err}), 0, "flags in reset");
        rst_n = 1;
        step();
        check("R1", 32'(used_map), 0, "used_map after reset");

        // exhaustive sweep over all codes (R2..R9, R10)
        for (int c = 0; c < 256; c++) begin
            m = expect_mask(8'(c));
            exp_used = '0;
            for (int i = 0; i < 10; i++) begin
                if (m[i]) begin
                    do_alloc(8'(c));
                    exp_used[i] = 1;
                    check(req_of(8'(c)), 32'(grant_valid), 1, $sformatf("R8 grant_valid code %0h", c));
                    check(req_of(8'(c)), 32'(grant_idx), 32'(i), $sformatf("R8 grant_idx code %0h", c));
                    check("R8", 32'(used_map), 32'(exp_used), $sformatf("used after grant code %0h", c));
                end
            end
            do_alloc(8'(c));
            check("R9", 32'({grant_valid, grant_fail}), 1, $sformatf("fail flags code %0h", c));
            check("R9", 32'(used_map), 32'(exp_used), $sformatf("used unchanged on fail code %0h", c));
            for (int i = 9; i >= 0; i--) begin
                if (exp_used[i]) begin
                    do_release(i);
                    exp_used[i] = 0;
                    check("R10", 32'(used_map), 32'(exp_used), $sformatf("release %0d", i));
                    check("R10", 32'(rel_err), 0, "rel_err on good release");
                end
            end
        end

        // R12: releases of idle and out-of-range indices
        do_alloc(8'h10);
        check("R2", 32'(grant_idx), 2, "general code lands on 2");
        do_release(3);
        check("R12", 32'(rel_err), 1, "rel_err idle counter");
        check("R12", 32'(used_map), 32'(10'b00_0000_0100), "used after idle release");
        do_release(12);
        check("R12", 32'(rel_err), 1, "rel_err index 12");
        check("R12", 32'(used_map), 32'(10'b00_0000_0100), "used after bad index");
        step();
        check("R12", 32'(rel_err), 0, "rel_err is one pulse");

        // R7 with partial occupancy: 2 busy, take 3 and 4, then 0xF5 goes to 6
        do_alloc(8'h10); check("R8", 32'(grant_idx), 3, "second general");
        do_alloc(8'h10); check("R8", 32'(grant_idx), 4, "third general");
        do_alloc(8'hF5); check("R7", 32'(grant_idx), 6, "even-set skips busy 2,4");
        do_alloc(8'hF8); check("R7", 32'(grant_idx), 5, "mid-set takes 5");
        do_alloc(8'hF8); check("R7", 32'(grant_idx), 7, "mid-set takes 7");
        do_alloc(8'hF8); check("R9", 32'(grant_fail), 1, "mid-set exhausted");
        do_alloc(8'h02); check("R3", 32'(grant_idx), 0, "cycle event takes 0");
        do_alloc(8'h8C); check("R4", 32'(grant_idx), 1, "instr event takes 1");
        check("R8", 32'(used_map), 32'(10'b00_1111_1111), "used after mix");

        // R11: release 7 and allocate 0x01 (only 7) in same cycle
        rel_req = 1; rel_idx = 4'd7; alloc_req = 1; alloc_code = 8'h01;
        step();
        check("R11", 32'(grant_valid), 1, "grant with same-cycle release");
        check("R11", 32'(grant_idx), 7, "freed counter granted");
        check("R11", 32'(rel_err), 0, "no rel_err");
        check("R11", 32'(used_map), 32'(10'b00_1111_1111), "used after swap");
        // release idle 9 while allocating 0x9F: rel ignored, alloc fails
        rel_req = 1; rel_idx = 4'd9; alloc_req = 1; alloc_code = 8'h9F;
        step();
        check("R12", 32'({rel_err, grant_fail}), 3, "idle release with failing alloc");
        check("R12", 32'(used_map), 32'(10'b00_1111_1111), "used unchanged");

        done = 1;
        summary();
    end
endmodule